// File: doc/BRIEF.md
# Windowed Result Watchdog

This block watches a stream of conversion results and raises a per-channel alarm when a result falls inside or outside a programmed window. Each result arrives as a single-cycle valid strobe carrying the channel number, a 16-bit value and the conversion sequence that produced it (sequence A or sequence B). The value is taken as written to the result register, after alignment and averaging.

A result is compared only when four conditions hold:
- the watchdog is enabled;
- the channel is selected in the channel mask;
- the sequence filter admits the result's sequence;
- the channel number is below the channel count.

If such a result meets the comparison, the flag for that channel is set. The flag stays set until it is cleared. The flags can be cleared all together, or one channel at a time.

The interrupt output follows the flag register. It is the OR of all flags, gated by an interrupt enable that is separate from the watchdog enable.

Top module: `win_watch`

## Requirements
- R1: With `cmp_mode`=0 (outside-window mode), a qualified result sets its flag when `res_val` < `lim_lo` or `res_val` > `lim_hi`. Values equal to either limit do not set it.
- R2: With `cmp_mode`=1 (inside-window mode), a qualified result sets its flag when `lim_lo` <= `res_val` <= `lim_hi`. Both limits are inclusive.
- R3: `res_seq` is 0 for sequence A and 1 for sequence B. `seq_sel` admits results as follows: 0 or 3 admits both sequences, 1 admits only A, and 2 admits only B. A result from a sequence that is not admitted leaves the flags unchanged.
- R4: Only channels whose bit is set in `chan_mask` (bit i for channel i) are compared. A channel number of NCH or more is ignored.
- R5: While `wd_en` is 0, no flag becomes set.
- R6: A flag is set at the clock edge that samples its qualifying strobe. It then holds until a clear is applied.
- R7: `clr_all` clears every flag at the next edge. `clr_one` clears only the flag numbered `clr_chan` at the next edge.
- R8: When a clear and a new event on the same channel occur in the same cycle, that flag ends up set.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one flag is set. It follows the flag register with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_vld | input | 1 | Result strobe, one cycle per result |
| res_chan | input | CH_W (5) | Channel number of the result |
| res_val | input | DATA_W (16) | Aligned, averaged result value |
| res_seq | input | 1 | Source sequence: 0 = A, 1 = B |
| wd_en | input | 1 | Watchdog enable |
| irq_en | input | 1 | Interrupt enable |
| cmp_mode | input | 1 | 0 = outside window, 1 = inside window |
| seq_sel | input | 2 | Sequence filter |
| chan_mask | input | NCH (17) | Channels that are compared |
| lim_lo | input | DATA_W (16) | Lower limit |
| lim_hi | input | DATA_W (16) | Upper limit |
| clr_all | input | 1 | Clear all flags |
| clr_one | input | 1 | Clear the flag selected by clr_chan |
| clr_chan | input | CH_W (5) | Channel to clear |
| flags | output | NCH (17) | Sticky per-channel flags |
| irq | output | 1 | Gated OR of the flags |

## Verification
The assertions check on every cycle that:
- flags hold unless a clear is applied;
- a full clear with no event empties the register;
- an event survives a clear in the same cycle;
- a disabled watchdog sets no bit;
- a blocked sequence produces no event;
- `irq` tracks its enable and the flag vector.

The comparison thresholds, including the exact limit values in both modes, can only be shown by the bench's scenarios. The same holds for masking, out-of-range channel numbers and the single-channel clear, which a scoreboard compares edge by edge against an independent model.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        SEQ_BOTH   = 2'd0,
        SEQ_A_ONLY = 2'd1,
        SEQ_B_ONLY = 2'd2,
        SEQ_BOTH_2 = 2'd3
    } seq_filter_e;

    typedef enum logic {
        MODE_OUTSIDE = 1'b0,
        MODE_INSIDE  = 1'b1
    } cmp_mode_e;

    localparam logic SRC_A = 1'b0;
    localparam logic SRC_B = 1'b1;
endpackage

// File: rtl/wwc_compare.sv
module wwc_compare
    import wwc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic          en,
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic          mode,
    input  logic          seq,
    input  logic [1:0]    seq_sel,
    output logic          evt
);
    logic below_lo, above_hi, cond, seq_ok;

    always_comb begin
        below_lo = val < lo;
        above_hi = val > hi;
        if (mode == MODE_INSIDE) cond = !below_lo && !above_hi;
        else                     cond = below_lo || above_hi;
        case (seq_filter_e'(seq_sel))
            SEQ_A_ONLY: seq_ok = (seq == SRC_A);
            SEQ_B_ONLY: seq_ok = (seq == SRC_B);
            default:    seq_ok = 1'b1;
        endcase
        evt = vld && en && seq_ok && cond;
    end

    // R3: a blocked sequence never yields an event
    p_seq_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_sel == SEQ_A_ONLY && seq == SRC_B) || (seq_sel == SEQ_B_ONLY && seq == SRC_A)
        |-> !evt);
    // R5: a disabled watchdog never yields an event
    p_no_evt_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !evt);
endmodule

// File: rtl/wwc_flags.sv
module wwc_flags #(
    parameter int NCH = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_vec,
    input  logic [NCH-1:0] clr_vec,
    output logic [NCH-1:0] flags_q
);
    typedef struct packed {
        logic [NCH-1:0] flg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.flg = (st_q.flg & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flg;

    // R6: without a clear, no flag drops
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vec == '0 |=> ($past(flags_q) & ~flags_q) == '0);
    // R7: clearing everything with no event empties the register
    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&clr_vec) && set_vec == '0 |=> flags_q == '0);
    // R8: an event wins over a same-cycle clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec != '0 |=> (flags_q & $past(set_vec)) == $past(set_vec));
    // R6: at most one new flag per edge (one result per cycle)
    p_one_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $onehot0(flags_q & ~$past(flags_q)));
endmodule

// File: rtl/win_watch.sv
module win_watch
    import wwc_pkg::*;
#(
    parameter int NCH  = 17,
    parameter int DW   = DATA_W,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            res_vld,
    input  logic [CH_W-1:0] res_chan,
    input  logic [DW-1:0]   res_val,
    input  logic            res_seq,
    input  logic            wd_en,
    input  logic            irq_en,
    input  logic            cmp_mode,
    input  logic [1:0]      seq_sel,
    input  logic [NCH-1:0]  chan_mask,
    input  logic [DW-1:0]   lim_lo,
    input  logic [DW-1:0]   lim_hi,
    input  logic            clr_all,
    input  logic            clr_one,
    input  logic [CH_W-1:0] clr_chan,
    output logic [NCH-1:0]  flags,
    output logic            irq
);
    logic           evt;
    logic [NCH-1:0] set_vec, clr_vec;

    wwc_compare #(.DW(DW)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (res_vld),
        .en      (wd_en),
        .val     (res_val),
        .lo      (lim_lo),
        .hi      (lim_hi),
        .mode    (cmp_mode),
        .seq     (res_seq),
        .seq_sel (seq_sel),
        .evt     (evt)
    );

    // Decode per channel; numbers >= NCH match no lane.
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        assign set_vec[i] = evt && chan_mask[i] && (res_chan == CH_W'(i));
        assign clr_vec[i] = clr_all || (clr_one && (clr_chan == CH_W'(i)));
    end

    wwc_flags #(.NCH(NCH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags)
    );

    assign irq = irq_en && (flags != '0);

    // R5: disabled watchdog adds no flag
    p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> (flags & ~$past(flags)) == '0);
    // R4: an unmasked channel's strobe adds no flag when nothing else sets one
    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && (set_vec == '0) |=> (flags & ~$past(flags)) == '0);
    // R9: interrupt follows enable and flags
    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_en && flags != '0));
endmodule

// File: tb/win_watch_test.sv
module win_watch_test;
    localparam int NCH  = 17;
    localparam int CH_W = 5;
    localparam int DW   = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic res_vld = 0;
    logic [CH_W-1:0] res_chan = '0;
    logic [DW-1:0] res_val = '0;
    logic res_seq = 0;
    logic wd_en = 1;
    logic irq_en = 1;
    logic cmp_mode = 0;
    logic [1:0] seq_sel = 0;
    logic [NCH-1:0] chan_mask = '1;
    logic [DW-1:0] lim_lo = 16'd100;
    logic [DW-1:0] lim_hi = 16'd200;
    logic clr_all = 0;
    logic clr_one = 0;
    logic [CH_W-1:0] clr_chan = '0;
    logic [NCH-1:0] flags;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [NCH-1:0] f;
        logic           i;
        string          tag;
    } item_t;
    item_t sb[$];
    logic [NCH-1:0] exp_f = '0;

    always #4 clk = ~clk;

    win_watch #(.NCH(NCH)) uut (.*);

    task automatic check(input logic [NCH-1:0] af, input logic ai, input item_t e);
        checks++;
        if (af !== e.f || ai !== e.i) begin
            errors++;
            $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b", e.tag, af, ai, e.f, e.i);
        end
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) check(flags, irq, sb.pop_front());
    end

    // Driver: compute expected from requirements, push, apply
    task automatic step(input logic vld, input int ch, input int val, input logic seq,
                        input logic ca, input logic co, input int cch, input string tag);
        logic seq_ok, cond, hit;
        logic [NCH-1:0] setm, clrm;
        item_t it;
        @(negedge clk);
        res_vld = vld; res_chan = CH_W'(ch); res_val = DW'(val); res_seq = seq;
        clr_all = ca; clr_one = co; clr_chan = CH_W'(cch);
        seq_ok = (seq_sel == 2'd1) ? (seq == 1'b0) : (seq_sel == 2'd2) ? (seq == 1'b1) : 1'b1;
        cond = cmp_mode ? (val >= lim_lo && val <= lim_hi) : (val < lim_lo || val > lim_hi);
        hit = vld && wd_en && seq_ok && cond && ch < NCH && chan_mask[ch % NCH];
        setm = hit ? (NCH'(1) << ch) : '0;
        clrm = ca ? '1 : (co && cch < NCH) ? (NCH'(1) << cch) : '0;
        exp_f = (exp_f & ~clrm) | setm;
        it.f = exp_f; it.i = irq_en && (exp_f != '0); it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
        #3;
        res_vld = 0; clr_all = 0; clr_one = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (flags !== '0 || irq !== 1'b0) begin
            errors++;
            $display("FAIL reset R6: flags=%h irq=%b expected 0 0", flags, irq);
        end
        rst_n = 1;
        @(posedge clk); #3;

        // R1 outside-window mode
        cmp_mode = 0;
        step(1, 0, 50, 0, 0, 0, 0, "R1 below lo sets");
        step(1, 1, 150, 0, 0, 0, 0, "R1 inside no set");
        step(1, 2, 250, 0, 0, 0, 0, "R1 above hi sets");
        step(1, 3, 100, 0, 0, 0, 0, "R1 equal lo no set");
        step(1, 4, 200, 0, 0, 0, 0, "R1 equal hi no set");
        step(0, 0, 0, 0, 0, 0, 0, "R6 flags hold");
        step(0, 0, 0, 0, 1, 0, 0, "R7 clear all");

        // R2 inside-window mode
        cmp_mode = 1;
        step(1, 5, 100, 0, 0, 0, 0, "R2 equal lo sets");
        step(1, 6, 200, 0, 0, 0, 0, "R2 equal hi sets");
        step(1, 7, 99, 0, 0, 0, 0, "R2 below no set");
        step(1, 8, 201, 0, 0, 0, 0, "R2 above no set");
        step(0, 0, 0, 0, 0, 1, 5, "R7 clear one channel");

        // R3 sequence filter
        seq_sel = 2'd1;
        step(1, 9, 150, 1, 0, 0, 0, "R3 A-only blocks B");
        step(1, 9, 150, 0, 0, 0, 0, "R3 A-only admits A");
        seq_sel = 2'd2;
        step(1, 10, 150, 0, 0, 0, 0, "R3 B-only blocks A");
        step(1, 10, 150, 1, 0, 0, 0, "R3 B-only admits B");
        seq_sel = 2'd3;
        step(1, 11, 150, 1, 0, 0, 0, "R3 code 3 admits B");
        seq_sel = 2'd0;
        step(1, 12, 150, 0, 0, 0, 0, "R3 code 0 admits A");

        // R4 mask and range
        chan_mask[13] = 1'b0;
        step(1, 13, 150, 0, 0, 0, 0, "R4 masked channel ignored");
        chan_mask[13] = 1'b1;
        step(1, 20, 150, 0, 0, 0, 0, "R4 out-of-range channel ignored");

        // R5 global enable
        wd_en = 0;
        step(1, 16, 150, 0, 0, 0, 0, "R5 disabled no set");
        wd_en = 1;
        step(1, 16, 150, 0, 0, 0, 0, "R5 enabled sets");

        // R8 clear and event together
        step(1, 14, 150, 0, 0, 0, 0, "R6 set ch14");
        step(1, 14, 150, 0, 0, 1, 14, "R8 clr_one vs event");
        step(1, 15, 150, 0, 1, 0, 0, "R8 clr_all vs event");

        // R9 interrupt gating
        irq_en = 0;
        step(0, 0, 0, 0, 0, 0, 0, "R9 irq gated off");
        irq_en = 1;
        step(0, 0, 0, 0, 0, 0, 0, "R9 irq with flags");
        step(0, 0, 0, 0, 1, 0, 0, "R9 irq drops after clear");

        repeat (2) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule